// File: doc/BRIEF.md
# Warp Issue Scheduler

This block decides, once per scheduler cycle, which resident warp of a streaming multiprocessor is sent to one of two execution pipes. One pipe is the scalar arithmetic pipe. The other is the special-function pipe, which handles transcendental and interpolation work. The scheduler runs at half the execution clock. Its decisions alternate between the two pipes, so each pipe is offered one warp every two scheduler cycles. That is four execution clocks, which is exactly the time a pipe needs to run a whole warp as two sixteen-thread halves.

Each of the warp slots holds four pieces of state: whether the warp is ready, the class of its next instruction, whether that instruction is a multiply that directly follows a multiply-add of the same warp, and the warp's active-thread mask. An upstream stage loads a slot through a single update port. Issuing a warp consumes its slot until the next update. Divergent warps are handled by loading each path as a separate instruction, each with its own mask. A paired multiply is steered to the special-function pipe so that it overlaps the preceding multiply-add. If it cannot get the next special-function slot, it falls back to the arithmetic pipe. A saturating counter stops paired multiplies from crowding out ordinary special-function work.

Top module: `ws_issue_sched`

## Requirements
- R1: After reset no warp slot is ready and both issue-valid outputs are low. The first decision after reset belongs to the arithmetic pipe, so a special-function warp loaded in the first cycle issues in the second cycle.
- R2: Decisions alternate strictly: arithmetic slot, special slot, arithmetic slot, and so on. The two valid outputs are never high together, and neither is high in two consecutive cycles.
- R3: Class encoding, shared by `upd_cls`, `alu_cls` and `sfu_cls`: 0 = plain arithmetic, 1 = multiply, 2 = special function. The arithmetic pipe takes class 0 and unpaired class 1. Class 2 never issues on the arithmetic pipe, and an unpaired multiply never issues on the special pipe.
- R4: A paired multiply (`upd_paired`=1, class 1) is not offered to the arithmetic pipe until it has been offered one special slot. If it wins that slot, it issues on the special pipe with class 1.
- R5: A paired multiply that is offered a special slot and not granted falls back to the arithmetic pipe and issues there on a following arithmetic slot. It is not granted because `sfu_rdy` is low, special work wins the slot, or another paired multiply wins it.
- R6: On a special slot a paired multiply beats pending class 2 work. After PAIR_LIMIT (default 3) consecutive paired grants on the special pipe, pending class 2 work wins the next special slot, and a class 2 grant clears the count.
- R7: Each pipe chooses among its eligible warps round-robin, searching upward from the index after the warp it last granted and wrapping at the top. After reset, the search starts at warp 0. The pointer holds when the pipe grants nothing.
- R8: When a pipe's ready input is low in that pipe's slot, no warp is granted to it on that slot.
- R9: A grant clears the warp's ready state, so the warp issues once per update. `issue_mask` carries the mask loaded with that instruction in the same cycle as the valid output. Reloading the same warp with a different mask issues it again with the new mask.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Scheduler clock (half the execution clock) |
| rst | input | 1 | Synchronous active-high reset |
| upd_en | input | 1 | Load a warp slot with its next instruction |
| upd_wid | input | WID_W | Warp slot to load |
| upd_cls | input | 2 | Instruction class (R3 encoding) |
| upd_paired | input | 1 | Multiply directly follows a multiply-add of this warp |
| upd_mask | input | THREADS | Active-thread mask for this instruction |
| alu_rdy | input | 1 | Arithmetic pipe can accept a warp |
| sfu_rdy | input | 1 | Special pipe is free (low while it is busy with interpolation) |
| alu_vld | output | 1 | Warp issued to the arithmetic pipe |
| alu_wid | output | WID_W | Warp issued to the arithmetic pipe |
| alu_cls | output | 2 | Class of the arithmetic-pipe issue |
| sfu_vld | output | 1 | Warp issued to the special pipe |
| sfu_wid | output | WID_W | Warp issued to the special pipe |
| sfu_cls | output | 2 | Class of the special-pipe issue |
| issue_mask | output | THREADS | Active-thread mask of the warp issued this cycle |

## Verification
The hardest case to reach is the pairing limit. Special work must stay pending while exactly one paired multiply becomes ready before each of several successive special slots. If two paired multiplies are ready at once, the loser falls back to the arithmetic pipe and the consecutive-grant count is never built. To get there, the stimulus first parks three special warps while the special pipe reports busy. It then aligns to the phase counted from reset and loads one paired multiply every two cycles, starting on a special slot. The expected order of special-pipe and arithmetic-pipe grants, including the fallback of the fourth multiply, follows from the round-robin pointer positions left by earlier scenarios.

// File: rtl/ws_pkg.sv
package ws_pkg;
  typedef enum logic [1:0] {
    CLS_ALU = 2'd0,
    CLS_MUL = 2'd1,
    CLS_SFU = 2'd2
  } wcls_e;
endpackage

// File: rtl/ws_rr_pick.sv
module ws_rr_pick #(
  parameter int N = 32,
  localparam int IW = $clog2(N)
) (
  input  logic [N-1:0]  req,
  input  logic [IW-1:0] last,
  output logic          hit,
  output logic [IW-1:0] idx
);
  int j;

  // search upward from the entry after the last grant, wrapping at N
  always_comb begin
    hit = 1'b0;
    idx = '0;
    j   = 0;
    for (int i = 1; i <= N; i++) begin
      j = (int'(last) + i) % N;
      if (!hit && req[j]) begin
        hit = 1'b1;
        idx = IW'(j);
      end
    end
  end
endmodule

// File: rtl/ws_warp_table.sv
module ws_warp_table
  import ws_pkg::*;
#(
  parameter int N = 32,
  parameter int T = 32,
  localparam int IW = $clog2(N)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          upd_en,
  input  logic [IW-1:0] upd_wid,
  input  wcls_e         upd_cls,
  input  logic          upd_paired,
  input  logic [T-1:0]  upd_mask,
  input  logic          clr_en,
  input  logic [IW-1:0] clr_wid,
  input  logic [N-1:0]  fb_set,
  input  logic [IW-1:0] rd_addr,
  output logic [T-1:0]  rd_mask,
  output logic [N-1:0]  rdy,
  output logic [N-1:0]  is_mul,
  output logic [N-1:0]  is_spc,
  output logic [N-1:0]  paired,
  output logic [N-1:0]  fb
);
  logic [T-1:0] mask_mem [N];

  // mask store: one write port, one registered read port
  always_ff @(posedge clk) begin
    if (upd_en) mask_mem[upd_wid] <= upd_mask;
    rd_mask <= mask_mem[rd_addr];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdy    <= '0;
      fb     <= '0;
      is_mul <= '0;
      is_spc <= '0;
      paired <= '0;
    end else begin
      for (int w = 0; w < N; w++) begin
        if (upd_en && upd_wid == IW'(w)) begin
          rdy[w]    <= 1'b1;
          fb[w]     <= 1'b0;
          is_mul[w] <= (upd_cls == CLS_MUL);
          is_spc[w] <= (upd_cls == CLS_SFU);
          paired[w] <= upd_paired;
        end else begin
          if (clr_en && clr_wid == IW'(w)) rdy[w] <= 1'b0;
          if (fb_set[w]) fb[w] <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/ws_issue_sched.sv
module ws_issue_sched
  import ws_pkg::*;
#(
  parameter int NUM_WARPS  = 32,
  parameter int THREADS    = 32,
  parameter int PAIR_LIMIT = 3,
  localparam int WID_W = $clog2(NUM_WARPS),
  localparam int CNT_W = $clog2(PAIR_LIMIT + 1)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               upd_en,
  input  logic [WID_W-1:0]   upd_wid,
  input  logic [1:0]         upd_cls,
  input  logic               upd_paired,
  input  logic [THREADS-1:0] upd_mask,
  input  logic               alu_rdy,
  input  logic               sfu_rdy,
  output logic               alu_vld,
  output logic [WID_W-1:0]   alu_wid,
  output logic [1:0]         alu_cls,
  output logic               sfu_vld,
  output logic [WID_W-1:0]   sfu_wid,
  output logic [1:0]         sfu_cls,
  output logic [THREADS-1:0] issue_mask
);
  localparam int N = NUM_WARPS;

  logic             phase_q;   // 0: arithmetic slot, 1: special slot
  logic [WID_W-1:0] alu_ptr, sfu_ptr;
  logic [CNT_W-1:0] pair_cnt;

  logic [N-1:0] rdy, is_mul, is_spc, paired, fb;
  logic [N-1:0] alu_req, pair_req, spc_req, fb_set, p_onehot;
  logic a_hit, p_hit, s_hit;
  logic [WID_W-1:0] a_idx, p_idx, s_idx, sfu_idx, clr_wid;
  logic take_pair, alu_go, sfu_go, clr_en;
  logic [THREADS-1:0] rd_mask;

  for (genvar w = 0; w < N; w++) begin : g_req
    assign alu_req[w]  = rdy[w] & ~is_spc[w] & (~is_mul[w] | ~paired[w] | fb[w]);
    assign pair_req[w] = rdy[w] & is_mul[w] & paired[w] & ~fb[w];
    assign spc_req[w]  = rdy[w] & is_spc[w];
  end

  ws_rr_pick #(.N(N)) u_alu_pick  (.req(alu_req),  .last(alu_ptr), .hit(a_hit), .idx(a_idx));
  ws_rr_pick #(.N(N)) u_pair_pick (.req(pair_req), .last(sfu_ptr), .hit(p_hit), .idx(p_idx));
  ws_rr_pick #(.N(N)) u_spc_pick  (.req(spc_req),  .last(sfu_ptr), .hit(s_hit), .idx(s_idx));

  always_comb begin
    take_pair = p_hit && ((pair_cnt < CNT_W'(PAIR_LIMIT)) || !s_hit);
    alu_go    = !phase_q && alu_rdy && a_hit;
    sfu_go    = phase_q && sfu_rdy && (p_hit || s_hit);
    sfu_idx   = take_pair ? p_idx : s_idx;
    p_onehot  = {{(N-1){1'b0}}, 1'b1} << p_idx;
    fb_set    = '0;
    if (phase_q)
      fb_set = pair_req & ~((sfu_go && take_pair) ? p_onehot : '0);
    clr_en  = alu_go || sfu_go;
    clr_wid = alu_go ? a_idx : sfu_idx;
  end

  ws_warp_table #(.N(N), .T(THREADS)) u_table (
    .clk(clk), .rst(rst),
    .upd_en(upd_en), .upd_wid(upd_wid), .upd_cls(wcls_e'(upd_cls)),
    .upd_paired(upd_paired), .upd_mask(upd_mask),
    .clr_en(clr_en), .clr_wid(clr_wid), .fb_set(fb_set),
    .rd_addr(clr_wid), .rd_mask(rd_mask),
    .rdy(rdy), .is_mul(is_mul), .is_spc(is_spc), .paired(paired), .fb(fb)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      phase_q  <= 1'b0;
      alu_ptr  <= WID_W'(N - 1);
      sfu_ptr  <= WID_W'(N - 1);
      pair_cnt <= '0;
      alu_vld  <= 1'b0;
      sfu_vld  <= 1'b0;
      alu_wid  <= '0;
      sfu_wid  <= '0;
      alu_cls  <= CLS_ALU;
      sfu_cls  <= CLS_SFU;
    end else begin
      phase_q <= ~phase_q;
      alu_vld <= alu_go;
      sfu_vld <= sfu_go;
      if (alu_go) begin
        alu_wid <= a_idx;
        alu_cls <= is_mul[a_idx] ? CLS_MUL : CLS_ALU;
        alu_ptr <= a_idx;
      end
      if (sfu_go) begin
        sfu_wid <= sfu_idx;
        sfu_cls <= take_pair ? CLS_MUL : CLS_SFU;
        sfu_ptr <= sfu_idx;
        if (!take_pair)
          pair_cnt <= '0;
        else if (pair_cnt < CNT_W'(PAIR_LIMIT))
          pair_cnt <= pair_cnt + 1'b1;
      end
    end
  end

  assign issue_mask = rd_mask & {THREADS{alu_vld | sfu_vld}};
endmodule

// File: rtl/ws_issue_sched_chk.sv
module ws_issue_sched_chk #(
  parameter int WID_W = 5
) (
  input logic             clk,
  input logic             rst,
  input logic             alu_rdy,
  input logic             sfu_rdy,
  input logic             alu_vld,
  input logic             sfu_vld,
  input logic [WID_W-1:0] alu_wid,
  input logic [1:0]       alu_cls,
  input logic [1:0]       sfu_cls
);
  // R2
  pipes_exclusive_chk: assert property (@(posedge clk) disable iff (rst)
    !(alu_vld && sfu_vld));
  // R2
  alu_spacing_chk: assert property (@(posedge clk) disable iff (rst)
    alu_vld |=> !alu_vld);
  // R2
  sfu_spacing_chk: assert property (@(posedge clk) disable iff (rst)
    sfu_vld |=> !sfu_vld);
  // R3
  alu_no_special_chk: assert property (@(posedge clk) disable iff (rst)
    alu_vld |-> alu_cls != 2'd2);
  // R3
  sfu_no_plain_chk: assert property (@(posedge clk) disable iff (rst)
    sfu_vld |-> sfu_cls != 2'd0);
  // R8
  alu_ready_chk: assert property (@(posedge clk) disable iff (rst)
    alu_vld |-> $past(alu_rdy));
  // R8
  sfu_ready_chk: assert property (@(posedge clk) disable iff (rst)
    sfu_vld |-> $past(sfu_rdy));
  // R9
  alu_wid_known_chk: assert property (@(posedge clk) disable iff (rst)
    alu_vld |-> !$isunknown(alu_wid));
endmodule

bind ws_issue_sched ws_issue_sched_chk #(.WID_W(WID_W)) u_chk (
  .clk(clk), .rst(rst), .alu_rdy(alu_rdy), .sfu_rdy(sfu_rdy),
  .alu_vld(alu_vld), .sfu_vld(sfu_vld), .alu_wid(alu_wid),
  .alu_cls(alu_cls), .sfu_cls(sfu_cls)
);

// File: tb/ws_issue_sched_bench.sv
`timescale 1ns/1ps
module ws_issue_sched_bench;
  localparam int NW = 32;
  localparam int TH = 32;
  localparam int WW = $clog2(NW);

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic upd_en = 1'b0;
  logic [WW-1:0] upd_wid = '0;
  logic [1:0] upd_cls = '0;
  logic upd_paired = 1'b0;
  logic [TH-1:0] upd_mask = '0;
  logic alu_rdy = 1'b1;
  logic sfu_rdy = 1'b1;
  logic alu_vld, sfu_vld;
  logic [WW-1:0] alu_wid, sfu_wid;
  logic [1:0] alu_cls, sfu_cls;
  logic [TH-1:0] issue_mask;

  always #2.5 clk = ~clk;

  ws_issue_sched u_ws_issue_sched (
    .clk(clk), .rst(rst), .upd_en(upd_en), .upd_wid(upd_wid), .upd_cls(upd_cls),
    .upd_paired(upd_paired), .upd_mask(upd_mask), .alu_rdy(alu_rdy), .sfu_rdy(sfu_rdy),
    .alu_vld(alu_vld), .alu_wid(alu_wid), .alu_cls(alu_cls),
    .sfu_vld(sfu_vld), .sfu_wid(sfu_wid), .sfu_cls(sfu_cls), .issue_mask(issue_mask)
  );

  typedef struct {
    bit          sfu;
    int          wid;
    int          cls;
    logic [31:0] mask;
    int          cyc;
    string       tag;
  } exp_t;

  exp_t exp_q[$];
  int n_chk = 0;
  int n_fail = 0;
  int cyc = 0;
  bit done = 1'b0;

  always @(posedge clk) cyc <= rst ? 0 : cyc + 1;

  task automatic check(input bit ok, input string tag, input string what,
                       input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  // driver: load a slot and predict its issue
  task automatic load(input int w, input int c, input bit p, input logic [31:0] m);
    upd_en = 1'b1; upd_wid = WW'(w); upd_cls = 2'(c); upd_paired = p; upd_mask = m;
    @(negedge clk);
    upd_en = 1'b0;
  endtask

  task automatic expect_issue(input bit s, input int w, input int c,
                              input logic [31:0] m, input int at, input string tag);
    exp_t e;
    e.sfu = s; e.wid = w; e.cls = c; e.mask = m; e.cyc = at; e.tag = tag;
    exp_q.push_back(e);
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  // next edge is a special slot when cyc is odd
  task automatic sync_sfu();
    while (cyc % 2 == 0) @(negedge clk);
  endtask

  task automatic drained(input string tag);
    check(exp_q.size() == 0, tag, "pending expected issues", exp_q.size(), 0);
    exp_q.delete();
  endtask

  // monitor: compare each issue with the head of the scoreboard
  task automatic observe(input bit s, input int w, input int c);
    exp_t e;
    if (exp_q.size() == 0) begin
      check(1'b0, "R9", s ? "unexpected special issue of warp" : "unexpected arith issue of warp",
            w, -1);
    end else begin
      e = exp_q.pop_front();
      check(e.sfu == s, e.tag, "pipe", s, e.sfu);
      check(e.wid == w, e.tag, "warp", w, e.wid);
      check(e.cls == c, e.tag, "class", c, e.cls);
      check(e.mask == issue_mask, e.tag, "mask", issue_mask, e.mask);
      if (e.cyc != 0) check(e.cyc == cyc, e.tag, "cycle", cyc, e.cyc);
    end
  endtask

  always @(negedge clk) begin
    if (!rst && !done) begin
      if (alu_vld) observe(1'b0, int'(alu_wid), int'(alu_cls));
      if (sfu_vld) observe(1'b1, int'(sfu_wid), int'(sfu_cls));
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      check(1'b0, "R2", "watchdog expired", 0, 1);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    // R1: reset state
    check(!alu_vld && !sfu_vld, "R1", "valids after reset", {alu_vld, sfu_vld}, 0);
    check(issue_mask == '0, "R1", "mask after reset", issue_mask, 0);
    // R1: first slot is arithmetic, so special warp issues in cycle 2
    expect_issue(1, 9, 2, 32'hA5A5_0001, 2, "R1");
    load(9, 2, 0, 32'hA5A5_0001);
    idle(6);
    drained("R1");

    // R7 / R8: arithmetic pipe held, then round-robin from warp 0
    alu_rdy = 1'b0;
    load(3, 0, 0, 32'h0000_0003);
    load(7, 0, 0, 32'h0000_0007);
    load(20, 0, 0, 32'h0000_0020);
    idle(4);
    drained("R8");
    expect_issue(0, 3, 0, 32'h0000_0003, 0, "R7");
    expect_issue(0, 7, 0, 32'h0000_0007, 0, "R7");
    expect_issue(0, 20, 0, 32'h0000_0020, 0, "R7");
    alu_rdy = 1'b1;
    idle(8);
    drained("R7");

    // R7: wrap past the top after last grant 20
    alu_rdy = 1'b0;
    load(5, 0, 0, 32'h0000_0005);
    load(25, 0, 0, 32'h0000_0025);
    expect_issue(0, 25, 0, 32'h0000_0025, 0, "R7");
    expect_issue(0, 5, 0, 32'h0000_0005, 0, "R7");
    alu_rdy = 1'b1;
    idle(6);
    drained("R7");

    // R9: divergent warp issued twice with each path's mask
    idle(6);
    expect_issue(0, 6, 0, 32'h0000_FFFF, 0, "R9");
    load(6, 0, 0, 32'h0000_FFFF);
    idle(4);
    expect_issue(0, 6, 0, 32'hFFFF_0000, 0, "R9");
    load(6, 0, 0, 32'hFFFF_0000);
    idle(4);
    drained("R9");

    // R7: pointer held at 6 through idle slots, so 30 precedes 4
    idle(6);
    alu_rdy = 1'b0;
    load(4, 0, 0, 32'h0000_0004);
    load(30, 0, 0, 32'h0000_0030);
    expect_issue(0, 30, 0, 32'h0000_0030, 0, "R7");
    expect_issue(0, 4, 0, 32'h0000_0004, 0, "R7");
    alu_rdy = 1'b1;
    idle(6);
    drained("R7");

    // R4: paired multiply goes to the special pipe
    expect_issue(1, 12, 1, 32'h1212_1212, 0, "R4");
    load(12, 1, 1, 32'h1212_1212);
    idle(6);
    // R3: unpaired multiply stays on the arithmetic pipe
    expect_issue(0, 14, 1, 32'h1414_1414, 0, "R3");
    load(14, 1, 0, 32'h1414_1414);
    idle(6);
    drained("R3");

    // R5: special pipe busy, paired multiply falls back
    sfu_rdy = 1'b0;
    expect_issue(0, 17, 1, 32'h1717_1717, 0, "R5");
    load(17, 1, 1, 32'h1717_1717);
    idle(6);
    drained("R5");

    // R6: pairing priority and limit; R3 special work never on arithmetic pipe
    load(1, 2, 0, 32'h0101_0101);
    load(2, 2, 0, 32'h0202_0202);
    load(3, 2, 0, 32'h0303_0303);
    idle(3);
    sync_sfu();
    sfu_rdy = 1'b1;
    expect_issue(1, 1, 2, 32'h0101_0101, 0, "R6");
    expect_issue(1, 10, 1, 32'h1010_1010, 0, "R6");
    expect_issue(1, 11, 1, 32'h1111_1111, 0, "R6");
    expect_issue(1, 13, 1, 32'h1313_1313, 0, "R6");
    expect_issue(1, 2, 2, 32'h0202_0202, 0, "R6");
    expect_issue(0, 15, 1, 32'h1515_1515, 0, "R5");
    expect_issue(1, 3, 2, 32'h0303_0303, 0, "R6");
    load(10, 1, 1, 32'h1010_1010);
    idle(1);
    load(11, 1, 1, 32'h1111_1111);
    idle(1);
    load(13, 1, 1, 32'h1313_1313);
    idle(1);
    load(15, 1, 1, 32'h1515_1515);
    idle(12);
    drained("R6");

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule